// File: doc/BRIEF.md
# Halt Sequencer with Dual Sleep Depth

This block sequences a small microcontroller into and out of its two deepest sleep states. When the CPU reports that it has executed its halt instruction, the sequencer looks at the real-time-clock interrupt-enable input. With the enable set, it chooses the shallow sleep, called active-halt. In that state the main oscillator and the RTC counter keep running while the CPU and peripheral clocks stop. With the enable clear, it chooses full halt, where the oscillator also stops.

On entry to either sleep state the block issues a one-cycle write of the value binary 10 to the CPU's 2-bit interrupt-mask field, which enables interrupts. A wake source that is already asserted therefore brings the part out on the following cycle. An interrupt wake from active-halt restarts the CPU at once, and the CPU then services that interrupt. A reset wake, and every wake from full halt, first passes through an oscillator stabilisation wait whose length is chosen by an input. Only then is the CPU released.

While the part sits in active-halt, a pause output holds the watchdog. In that state the periodic RTC interrupt is what bounds the time spent asleep. The CPU, the interrupt priority logic and the oscillator circuit itself lie outside the block; they appear only as request and enable pins.

Top module: `lp_halt_ctrl`

## Requirements
- R1: In RUN, a high `halt_req` moves the state to ACTIVE_HALT (code 1) when `rtc_ie` is 1, or to FULL_HALT (code 2) when `rtc_ie` is 0. RUN is code 0 and WAKE_DELAY is code 3 on `state_o`.
- R2: The clock enables follow the state as `{cpu_clk_en, periph_clk_en, osc_en}`: RUN gives 111, ACTIVE_HALT gives 001, FULL_HALT gives 000, and WAKE_DELAY gives 001.
- R3: In ACTIVE_HALT, `rtc_irq` or a wake-capable external line returns the state to RUN on the next cycle. That same cycle carries a `cpu_start` pulse with `resume_vec` = 0, meaning service the interrupt.
- R4: A `rst_req` in any state enters WAKE_DELAY, or restarts it if already there. WAKE_DELAY lasts DLY_SHORT cycles when `long_dly` = 0 and DLY_LONG cycles when `long_dly` = 1, with the choice sampled at the entering edge. It then returns to RUN with `cpu_start` = 1 and `resume_vec` = 1, meaning fetch the reset vector.
- R5: In FULL_HALT, `rtc_irq` has no effect. A wake-capable external line leads through WAKE_DELAY, with the same length rule as R4, to RUN with `cpu_start` = 1 and `resume_vec` = 0.
- R6: In the first cycle of either sleep state, `imask_we` is high for exactly one cycle with `imask_val` = 2'b10. A wake source already high at entry leaves the sleep state one cycle later.
- R7: `wdog_pause` is 1 exactly while the state is ACTIVE_HALT.
- R8: `wake_valid` pulses for one cycle in the cycle after a wake is taken. At the same time `wake_cause` shows 1 for RTC, 2 for an external line, or 3 for reset. In all other cycles `wake_valid` and `wake_cause` are 0.
- R9: `rst_req` wins over any interrupt in the same cycle, and in ACTIVE_HALT `rtc_irq` wins over an external line.
- R10: External line k wakes the part only when bit k of the EXT_WAKE_MASK parameter is 1. Other lines leave the state and `wake_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the sequencer |
| rst_n | input | 1 | Active-low asynchronous block reset |
| halt_req | input | 1 | CPU executed its halt instruction |
| rtc_ie | input | 1 | RTC interrupt enable; selects sleep depth |
| long_dly | input | 1 | Selects the long stabilisation wait |
| rtc_irq | input | 1 | RTC periodic interrupt request |
| ext_irq | input | EXT_LINES | External interrupt request lines |
| rst_req | input | 1 | Reset event acting as a wake source |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator and RTC counter enable |
| wdog_pause | output | 1 | Holds the watchdog during active-halt |
| imask_we | output | 1 | One-cycle write strobe for the interrupt mask |
| imask_val | output | 2 | Value written to the interrupt mask (2'b10) |
| state_o | output | 2 | Current state code |
| wake_valid | output | 1 | One-cycle wake indication |
| wake_cause | output | 2 | Cause of the wake (1 RTC, 2 external, 3 reset) |
| cpu_start | output | 1 | One-cycle CPU release pulse |
| resume_vec | output | 1 | With cpu_start: 0 serve interrupt, 1 reset vector |

## Verification
The bench builds the block with DLY_SHORT = 16, DLY_LONG = 40, EXT_LINES = 4 and EXT_WAKE_MASK = 4'b0111. The short waits let every wake path run to completion, and each WAKE_DELAY length can be counted cycle for cycle for both settings of `long_dly`. Leaving line 3 out of the mask allows a check that a line which cannot wake is ignored while the lines next to it still wake the part.

// File: rtl/lp_halt_pkg.sv
package lp_halt_pkg;

  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_ACT_HALT  = 2'd1,
    ST_FULL_HALT = 2'd2,
    ST_WAKE_DLY  = 2'd3
  } lp_state_e;

  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_RTC   = 2'd1,
    WK_EXT   = 2'd2,
    WK_RESET = 2'd3
  } wake_src_e;

  localparam logic [1:0] IMASK_ON_ENTRY = 2'b10;

endpackage

// File: rtl/lp_wake_arb.sv
module lp_wake_arb
  import lp_halt_pkg::*;
#(
  parameter int                   EXT_LINES     = 4,
  parameter logic [EXT_LINES-1:0] EXT_WAKE_MASK = '1
) (
  input  lp_state_e            state,
  input  logic                 rst_req,
  input  logic                 rtc_irq,
  input  logic [EXT_LINES-1:0] ext_irq,
  output wake_src_e            src
);

  logic [EXT_LINES-1:0] ext_ok;
  logic                 ext_any;

  // only lines flagged in the mask may wake the part
  for (genvar g = 0; g < EXT_LINES; g++) begin : g_line
    if (EXT_WAKE_MASK[g]) begin : g_cap
      assign ext_ok[g] = ext_irq[g];
    end else begin : g_blk
      assign ext_ok[g] = 1'b0;
    end
  end

  assign ext_any = |ext_ok;

  // reset first, then RTC, then external lines
  always_comb begin
    src = WK_NONE;
    if (rst_req) begin
      src = WK_RESET;
    end else begin
      unique case (state)
        ST_ACT_HALT: begin
          if (rtc_irq)      src = WK_RTC;
          else if (ext_any) src = WK_EXT;
        end
        ST_FULL_HALT: begin
          if (ext_any) src = WK_EXT;
        end
        default: src = WK_NONE;
      endcase
    end
  end

  // R10: blocked lines never produce an external wake
  always_comb begin
    if (src == WK_EXT) begin
      a_mask_r10: assert ((ext_irq & EXT_WAKE_MASK) != '0);
    end
  end

endmodule

// File: rtl/lp_stab_timer.sv
module lp_stab_timer #(
  parameter int DLY_SHORT = 256,
  parameter int DLY_LONG  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  input  logic run,
  output logic done
);

  localparam int CW = (DLY_LONG > 1) ? $clog2(DLY_LONG) : 1;
  localparam logic [CW-1:0] LD_S = CW'(DLY_SHORT - 1);
  localparam logic [CW-1:0] LD_L = CW'(DLY_LONG - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= long_sel ? LD_L : LD_S;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = run && !load && (cnt == '0);

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LD_L);

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/lp_clk_gate_dec.sv
module lp_clk_gate_dec
  import lp_halt_pkg::*;
(
  input  lp_state_e state,
  output logic      cpu_en,
  output logic      per_en,
  output logic      osc_en,
  output logic      wdog_pause
);

  always_comb begin
    cpu_en     = 1'b0;
    per_en     = 1'b0;
    osc_en     = 1'b0;
    wdog_pause = 1'b0;
    unique case (state)
      ST_RUN: begin
        cpu_en = 1'b1;
        per_en = 1'b1;
        osc_en = 1'b1;
      end
      ST_ACT_HALT: begin
        osc_en     = 1'b1;
        wdog_pause = 1'b1;
      end
      ST_WAKE_DLY: osc_en = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/lp_halt_ctrl.sv
module lp_halt_ctrl
  import lp_halt_pkg::*;
#(
  parameter int                   DLY_SHORT     = 256,
  parameter int                   DLY_LONG      = 4096,
  parameter int                   EXT_LINES     = 4,
  parameter logic [EXT_LINES-1:0] EXT_WAKE_MASK = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 halt_req,
  input  logic                 rtc_ie,
  input  logic                 long_dly,
  input  logic                 rtc_irq,
  input  logic [EXT_LINES-1:0] ext_irq,
  input  logic                 rst_req,
  output logic                 cpu_clk_en,
  output logic                 periph_clk_en,
  output logic                 osc_en,
  output logic                 wdog_pause,
  output logic                 imask_we,
  output logic [1:0]           imask_val,
  output logic [1:0]           state_o,
  output logic                 wake_valid,
  output logic [1:0]           wake_cause,
  output logic                 cpu_start,
  output logic                 resume_vec
);

  lp_state_e state_q, state_d;
  wake_src_e src, cause_q;
  logic      enter_d, start_d, vec_d, vec_q, tmr_load, tmr_done;
  logic      wake_q, imask_q, start_q;

  lp_wake_arb #(
    .EXT_LINES    (EXT_LINES),
    .EXT_WAKE_MASK(EXT_WAKE_MASK)
  ) u_arb (
    .state  (state_q),
    .rst_req(rst_req),
    .rtc_irq(rtc_irq),
    .ext_irq(ext_irq),
    .src    (src)
  );

  lp_stab_timer #(
    .DLY_SHORT(DLY_SHORT),
    .DLY_LONG (DLY_LONG)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .long_sel(long_dly),
    .run     (state_q == ST_WAKE_DLY),
    .done    (tmr_done)
  );

  lp_clk_gate_dec u_gate (
    .state     (state_q),
    .cpu_en    (cpu_clk_en),
    .per_en    (periph_clk_en),
    .osc_en    (osc_en),
    .wdog_pause(wdog_pause)
  );

  always_comb begin
    state_d  = state_q;
    enter_d  = 1'b0;
    start_d  = 1'b0;
    vec_d    = vec_q;
    tmr_load = 1'b0;
    if (src == WK_RESET) begin
      state_d  = ST_WAKE_DLY;
      tmr_load = 1'b1;
      vec_d    = 1'b1;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (halt_req) begin
            state_d = rtc_ie ? ST_ACT_HALT : ST_FULL_HALT;
            enter_d = 1'b1;
          end
        end
        ST_ACT_HALT: begin
          if (src != WK_NONE) begin
            state_d = ST_RUN;
            start_d = 1'b1;
            vec_d   = 1'b0;
          end
        end
        ST_FULL_HALT: begin
          if (src == WK_EXT) begin
            state_d  = ST_WAKE_DLY;
            tmr_load = 1'b1;
            vec_d    = 1'b0;
          end
        end
        ST_WAKE_DLY: begin
          if (tmr_done) begin
            state_d = ST_RUN;
            start_d = 1'b1;
          end
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cause_q <= WK_NONE;
      wake_q  <= 1'b0;
      imask_q <= 1'b0;
      start_q <= 1'b0;
      vec_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cause_q <= src;
      wake_q  <= (src != WK_NONE);
      imask_q <= enter_d;
      start_q <= start_d;
      vec_q   <= vec_d;
    end
  end

  assign state_o    = state_q;
  assign wake_valid = wake_q;
  assign wake_cause = cause_q;
  assign imask_we   = imask_q;
  assign imask_val  = IMASK_ON_ENTRY;
  assign cpu_start  = start_q;
  assign resume_vec = vec_q;

  p_sleep_no_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |-> !cpu_clk_en && !periph_clk_en);

  p_full_halt_osc_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FULL_HALT) |-> !osc_en);

  p_select_depth_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && halt_req && !rst_req) |=>
      (state_q == (($past(rtc_ie)) ? ST_ACT_HALT : ST_FULL_HALT)));

  p_ah_irq_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACT_HALT && rtc_irq && !rst_req) |=>
      (state_q == ST_RUN && cpu_start && !resume_vec));

  p_fh_rtc_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FULL_HALT && !rst_req && (ext_irq & EXT_WAKE_MASK) == '0) |=>
      (state_q == ST_FULL_HALT));

  p_imask_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    imask_we |=> !imask_we);

  p_wake_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && !rst_req) |=> !wake_valid);

  p_rst_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (state_q == ST_WAKE_DLY && wake_cause == 2'd3));

endmodule

// File: tb/lp_halt_ctrl_tb_top.sv
module lp_halt_ctrl_tb_top;

  localparam int DS = 16;
  localparam int DL = 40;
  localparam int NL = 4;
  localparam logic [NL-1:0] WMASK = 4'b0111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, rtc_ie = 0, long_dly = 0, rtc_irq = 0, rst_req = 0;
  logic [NL-1:0] ext_irq = '0;
  logic cpu_clk_en, periph_clk_en, osc_en, wdog_pause, imask_we;
  logic [1:0] imask_val, state_o, wake_cause;
  logic wake_valid, cpu_start, resume_vec;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lp_halt_ctrl #(
    .DLY_SHORT(DS), .DLY_LONG(DL), .EXT_LINES(NL), .EXT_WAKE_MASK(WMASK)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .rtc_ie(rtc_ie),
    .long_dly(long_dly), .rtc_irq(rtc_irq), .ext_irq(ext_irq),
    .rst_req(rst_req), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .wdog_pause(wdog_pause), .imask_we(imask_we), .imask_val(imask_val),
    .state_o(state_o), .wake_valid(wake_valid), .wake_cause(wake_cause),
    .cpu_start(cpu_start), .resume_vec(resume_vec)
  );

  // src: 0 rtc, 1 external line, 2 reset
  typedef struct packed {
    logic       ie;
    logic [1:0] src;
    logic [1:0] line;
    logic       lng;
    logic [1:0] exp_st;
    logic [1:0] exp_cause;
    logic [7:0] exp_dly;
    logic       exp_vec;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 2'd0, 2'd0, 1'b0, 2'd1, 2'd1, 8'd0,  1'b0},
    '{1'b1, 2'd1, 2'd0, 1'b0, 2'd1, 2'd2, 8'd0,  1'b0},
    '{1'b1, 2'd2, 2'd0, 1'b0, 2'd1, 2'd3, 8'd16, 1'b1},
    '{1'b0, 2'd1, 2'd2, 1'b1, 2'd2, 2'd2, 8'd40, 1'b0},
    '{1'b0, 2'd2, 2'd0, 1'b1, 2'd2, 2'd3, 8'd40, 1'b1},
    '{1'b0, 2'd1, 2'd1, 1'b0, 2'd2, 2'd2, 8'd16, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // count cycles spent in WAKE_DELAY, then check the release
  task automatic finish_delay(input string req, input int n_exp, input int vec_exp);
    int n = 0;
    while (state_o == 2'd3 && n < 5000) begin
      check({req, " osc on in delay"}, {cpu_clk_en, osc_en}, 1);
      n++;
      tick();
    end
    check({req, " delay length"}, n, n_exp);
    check({req, " back in RUN"}, state_o, 0);
    check({req, " cpu_start"}, cpu_start, 1);
    check({req, " resume_vec"}, resume_vec, vec_exp);
  endtask

  task automatic enter_sleep(input logic ie);
    rtc_ie = ie; halt_req = 1'b1;
    tick();
    halt_req = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // reset state
    check("R2 reset enables", {cpu_clk_en, periph_clk_en, osc_en}, 3'b111);
    check("R1 reset state RUN", state_o, 0);
    check("R8 no wake after reset", {wake_valid, wake_cause}, 0);
    check("R6 no mask write after reset", imask_we, 0);
    check("R7 pause low in RUN", wdog_pause, 0);

    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      long_dly = v.lng;
      enter_sleep(v.ie);
      check("R1 sleep depth", state_o, v.exp_st);
      check("R6 mask write strobe", imask_we, 1);
      check("R6 mask value", imask_val, 2'b10);
      check("R2 sleep enables", {cpu_clk_en, periph_clk_en, osc_en},
            (v.exp_st == 2'd1) ? 3'b001 : 3'b000);
      check("R7 pause", wdog_pause, (v.exp_st == 2'd1) ? 1 : 0);
      case (v.src)
        2'd0: rtc_irq = 1'b1;
        2'd1: ext_irq = NL'(1) << v.line;
        default: rst_req = 1'b1;
      endcase
      tick();
      rtc_irq = 1'b0; ext_irq = '0; rst_req = 1'b0;
      check("R8 wake pulse", wake_valid, 1);
      check("R8 wake cause", wake_cause, v.exp_cause);
      if (v.exp_dly == 0) begin
        check("R3 immediate RUN", state_o, 0);
        check("R3 cpu_start", cpu_start, 1);
        check("R3 resume_vec", resume_vec, 0);
      end else begin
        check("R4 R5 in delay", state_o, 3);
        finish_delay((v.src == 2'd2) ? "R4" : "R5", v.exp_dly, v.exp_vec);
      end
      tick();
      check("R8 pulse ends", wake_valid, 0);
    end

    // pending interrupt at entry wakes on the next cycle
    ext_irq = 4'b0001;
    enter_sleep(1'b1);
    check("R6 pending entry state", state_o, 1);
    tick();
    ext_irq = '0;
    check("R6 pending wakes next cycle", state_o, 0);
    check("R6 pending cause", wake_cause, 2);
    tick();

    // line 3 cannot wake
    enter_sleep(1'b1);
    ext_irq = 4'b1000;
    tick(); tick(); tick();
    check("R10 blocked line keeps sleep", state_o, 1);
    check("R10 blocked line no wake", wake_valid, 0);
    ext_irq = '0;
    rtc_irq = 1'b1; tick(); rtc_irq = 1'b0;
    check("R3 rtc wake after blocked line", state_o, 0);
    tick();

    // RTC has no effect in full halt
    long_dly = 1'b0;
    enter_sleep(1'b0);
    rtc_irq = 1'b1;
    tick(); tick(); tick();
    rtc_irq = 1'b0;
    check("R5 rtc ignored in full halt", state_o, 2);
    check("R5 no wake from rtc", wake_valid, 0);
    check("R2 osc stays off", osc_en, 0);
    rst_req = 1'b1; tick(); rst_req = 1'b0;
    finish_delay("R4", DS, 1);
    tick();

    // reset beats both interrupts
    enter_sleep(1'b1);
    rtc_irq = 1'b1; ext_irq = 4'b0001; rst_req = 1'b1;
    tick();
    rtc_irq = 1'b0; ext_irq = '0; rst_req = 1'b0;
    check("R9 reset wins state", state_o, 3);
    check("R9 reset wins cause", wake_cause, 3);
    finish_delay("R9", DS, 1);
    tick();

    // RTC beats external
    enter_sleep(1'b1);
    rtc_irq = 1'b1; ext_irq = 4'b0010;
    tick();
    rtc_irq = 1'b0; ext_irq = '0;
    check("R9 rtc over external", wake_cause, 1);
    tick();

    // reset while running, restart of the wait mid-way
    long_dly = 1'b1;
    rst_req = 1'b1; tick(); rst_req = 1'b0;
    check("R4 reset from RUN", state_o, 3);
    for (int k = 0; k < 5; k++) tick();
    long_dly = 1'b0;
    rst_req = 1'b1; tick(); rst_req = 1'b0;
    finish_delay("R4 restart", DS, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule